// File: doc/BRIEF.md
# Battery Pack Switch Supervisor

This block holds the on/off decision for the two series switches of a rechargeable pack: one that passes charge current and one that passes load current. It takes the outcome of each cell polling window as per-cell "above the high limit" and "below the low limit" flags, together with comparator outputs for load overcurrent and for a short circuit, plus indications that a charger has been attached or the load has been taken away. From these it qualifies faults, times them, latches them and releases them, and drives registered enables for the two switch drivers. An active-low undervoltage fault pin and a sleep indicator are also produced.

Charge-side and discharge-side faults have separate latches. A high-voltage cell blocks charging after one flagged window or after two back to back, chosen by a select pin, and a window with no high flag frees it again. A low-voltage cell must be seen in two back-to-back windows; the fault pin then falls and a fixed countdown starts that nothing but reset can stop, ending in a sleep state with the discharge switch off, which only a charger ends. Overcurrent is qualified by how long it lasts, with a much shorter window at short-circuit level. Two active-low inhibit pins and a test-hold pin give outside control over the switches. All delays are whole numbers of a tick of `TICK_DIV` clocks.

Top module: `pack_guard_ctrl`

## Requirements
- R1: After reset, with no fault present, `chg_en`=1, `dsg_en`=1, `uv_fault_n`=1 and `sleep`=0.
- R2: With `ov_two_sel`=0, a window (`sample_vld`=1) in which any bit of `cell_over` is 1 makes `chg_en` 0 on the second rising edge counting the sampling edge as the first.
- R3: With `ov_two_sel`=1, one flagged window leaves `chg_en` at 1; two back-to-back flagged windows clear it; a window with no high flag between them restarts the count.
- R4: A window with all bits of `cell_over` at 0 releases the charge latch, and `chg_en` returns to 1 on the second rising edge counting the sampling edge as the first.
- R5: Two back-to-back windows with any bit of `cell_under` set drive `uv_fault_n` to 0 on the second edge counting the second sampling edge as the first; a clean window in between restarts the count.
- R6: `SLEEP_TICKS`*`TICK_DIV`+2 edges after the second low window, `sleep` becomes 1 and `dsg_en` 0; a charger seen during the countdown changes neither its length nor the fault pin.
- R7: Sleep ends only when `charger_det` is 1; two edges later `sleep`=0, `uv_fault_n`=1 and `dsg_en`=1.
- R8: `oc_hit` held without break for `OC_TICKS`*`TICK_DIV`+2 edges makes `dsg_en` 0, one edge fewer leaves it at 1; a drop of `oc_hit` restarts the timing.
- R9: With `sc_hit` and `oc_hit` both held, the window becomes `SC_TICKS`*`TICK_DIV`+2 edges.
- R10: A latched overcurrent is released by one cycle of `load_gone` or of `charger_det`, with `dsg_en` back to 1 two edges after that cycle.
- R11: `chg_inh_n`=0 or `dsg_inh_n`=0 turns the matching enable off at the next edge; during sleep `chg_inh_n` has no effect on `chg_en`.
- R12: While `test_hold`=1 every latch is cleared and both enables read 1 from the next edge, and no fault returns after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_vld | input | 1 | One-cycle strobe at the end of a polling window |
| cell_over | input | N_CELLS | Per-cell high-limit flags, valid with the strobe |
| cell_under | input | N_CELLS | Per-cell low-limit flags, valid with the strobe |
| ov_two_sel | input | 1 | 0: one high window trips; 1: two back-to-back windows trip |
| oc_hit | input | 1 | Load overcurrent comparator |
| sc_hit | input | 1 | Short-circuit level comparator |
| charger_det | input | 1 | Charger attached |
| load_gone | input | 1 | Load taken away |
| chg_inh_n | input | 1 | Charge inhibit, active low |
| dsg_inh_n | input | 1 | Discharge inhibit, active low |
| test_hold | input | 1 | Holds the logic cleared with both switches on |
| chg_en | output | 1 | Charge switch enable |
| dsg_en | output | 1 | Discharge switch enable |
| uv_fault_n | output | 1 | Undervoltage fault, active low |
| sleep | output | 1 | Low-power sleep state |

## Verification
A wrong qualification count shows as `chg_en` or `uv_fault_n` moving one polling window early or late, visible two edges after the strobe. A timer that is off by a tick or fails to restart moves the discharge switch-off by `TICK_DIV` clocks, so the checks sample on both sides of the exact edge. A sleep or latch state that leaks through its release conditions shows as an enable stuck low after a charger or load-removal cycle, or as an inhibit taking effect while asleep.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [1:0] {
    UV_OK    = 2'd0,
    UV_SEEN  = 2'd1,
    UV_COUNT = 2'd2,
    UV_SLEEP = 2'd3
  } uv_state_t;
endpackage

// File: rtl/pgc_tmr.sv
module pgc_tmr #(
  parameter int DIV = 4,
  parameter int TW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          done
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre;
  logic [TW-1:0] ticks;

  assign done = (ticks >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre   <= '0;
      ticks <= '0;
    end else if (!done) begin
      if (pre == PW'(DIV - 1)) begin
        pre   <= '0;
        ticks <= ticks + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  a_r8_stop_restarts: assert property (@(posedge clk) disable iff (rst)
    (!run) |=> (ticks == '0 && pre == '0));
endmodule

// File: rtl/pgc_ovp.sv
module pgc_ovp #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp,
  input  logic [N-1:0] over,
  input  logic         two_sel,
  output logic         lat
);
  logic seen;
  logic any_over;

  assign any_over = |over;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0;
      lat  <= 1'b0;
    end else if (smp) begin
      if (any_over) begin
        if (!lat) begin
          if (!two_sel || seen) lat  <= 1'b1;
          else                  seen <= 1'b1;
        end
      end else begin
        seen <= 1'b0;
        lat  <= 1'b0;
      end
    end
  end

  a_r2_single_trips: assert property (@(posedge clk) disable iff (rst)
    (smp && any_over && !two_sel) |=> lat);
  a_r3_first_holds: assert property (@(posedge clk) disable iff (rst)
    (smp && any_over && two_sel && !seen && !lat) |=> !lat);
  a_r4_clean_frees: assert property (@(posedge clk) disable iff (rst)
    (smp && !any_over) |=> !lat);
endmodule

// File: rtl/pgc_uvp.sv
module pgc_uvp
  import pgc_pkg::*;
#(
  parameter int N           = 3,
  parameter int DIV         = 5000,
  parameter int SLEEP_TICKS = 160000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp,
  input  logic [N-1:0] under,
  input  logic         charger,
  output logic         fault,
  output logic         asleep
);
  localparam int TW = $clog2(SLEEP_TICKS + 1);

  uv_state_t st;
  logic      cnt_done;
  logic      any_under;

  assign any_under = |under;
  assign fault     = (st == UV_COUNT) || (st == UV_SLEEP);
  assign asleep    = (st == UV_SLEEP);

  pgc_tmr #(.DIV(DIV), .TW(TW)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (st == UV_COUNT),
    .limit (TW'(SLEEP_TICKS)),
    .done  (cnt_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= UV_OK;
    end else begin
      case (st)
        UV_OK:    if (smp && any_under) st <= UV_SEEN;
        UV_SEEN:  if (smp) st <= any_under ? UV_COUNT : UV_OK;
        UV_COUNT: if (cnt_done) st <= UV_SLEEP;
        UV_SLEEP: if (charger) st <= UV_OK;
        default:  st <= UV_OK;
      endcase
    end
  end

  a_r5_second_trips: assert property (@(posedge clk) disable iff (rst)
    (st == UV_SEEN && smp && any_under) |=> (st == UV_COUNT));
  a_r6_no_abort: assert property (@(posedge clk) disable iff (rst)
    (st == UV_COUNT) |=> (st == UV_COUNT || st == UV_SLEEP));
  a_r7_sleep_holds: assert property (@(posedge clk) disable iff (rst)
    (st == UV_SLEEP && !charger) |=> (st == UV_SLEEP));
endmodule

// File: rtl/pgc_ocp.sv
module pgc_ocp #(
  parameter int DIV      = 5000,
  parameter int OC_TICKS = 30,
  parameter int SC_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic oc,
  input  logic sc,
  input  logic load_gone,
  input  logic charger,
  output logic lat
);
  localparam int TW = $clog2(OC_TICKS + 1);

  logic          hit;
  logic          qual_done;
  logic [TW-1:0] win;

  assign hit = oc || sc;
  assign win = sc ? TW'(SC_TICKS) : TW'(OC_TICKS);

  pgc_tmr #(.DIV(DIV), .TW(TW)) u_qual (
    .clk   (clk),
    .rst   (rst),
    .run   (hit && !lat),
    .limit (win),
    .done  (qual_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lat <= 1'b0;
    end else if (load_gone || charger) begin
      lat <= 1'b0;
    end else if (hit && qual_done) begin
      lat <= 1'b1;
    end
  end

  a_r8_needs_hit: assert property (@(posedge clk) disable iff (rst)
    $rose(lat) |-> $past(hit));
  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    (load_gone || charger) |=> !lat);
endmodule

// File: rtl/pack_guard_ctrl.sv
module pack_guard_ctrl #(
  parameter int N_CELLS     = 3,
  parameter int TICK_DIV    = 5000,
  parameter int OC_TICKS    = 30,
  parameter int SC_TICKS    = 3,
  parameter int SLEEP_TICKS = 160000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sample_vld,
  input  logic [N_CELLS-1:0] cell_over,
  input  logic [N_CELLS-1:0] cell_under,
  input  logic               ov_two_sel,
  input  logic               oc_hit,
  input  logic               sc_hit,
  input  logic               charger_det,
  input  logic               load_gone,
  input  logic               chg_inh_n,
  input  logic               dsg_inh_n,
  input  logic               test_hold,
  output logic               chg_en,
  output logic               dsg_en,
  output logic               uv_fault_n,
  output logic               sleep
);
  logic core_rst;
  logic ov_lat;
  logic oc_lat;
  logic uv_fault;
  logic uv_sleep;

  assign core_rst = rst || test_hold;

  pgc_ovp #(.N(N_CELLS)) u_ovp (
    .clk     (clk),
    .rst     (core_rst),
    .smp     (sample_vld),
    .over    (cell_over),
    .two_sel (ov_two_sel),
    .lat     (ov_lat)
  );

  pgc_uvp #(.N(N_CELLS), .DIV(TICK_DIV), .SLEEP_TICKS(SLEEP_TICKS)) u_uvp (
    .clk     (clk),
    .rst     (core_rst),
    .smp     (sample_vld),
    .under   (cell_under),
    .charger (charger_det),
    .fault   (uv_fault),
    .asleep  (uv_sleep)
  );

  pgc_ocp #(.DIV(TICK_DIV), .OC_TICKS(OC_TICKS), .SC_TICKS(SC_TICKS)) u_ocp (
    .clk       (clk),
    .rst       (core_rst),
    .oc        (oc_hit),
    .sc        (sc_hit),
    .load_gone (load_gone),
    .charger   (charger_det),
    .lat       (oc_lat)
  );

  always_ff @(posedge clk) begin
    if (rst || test_hold) begin
      chg_en     <= 1'b1;
      dsg_en     <= 1'b1;
      uv_fault_n <= 1'b1;
      sleep      <= 1'b0;
    end else begin
      chg_en     <= !ov_lat && (uv_sleep || chg_inh_n);
      dsg_en     <= !uv_sleep && !oc_lat && dsg_inh_n;
      uv_fault_n <= !uv_fault;
      sleep      <= uv_sleep;
    end
  end

  a_r11_dsg_inhibit: assert property (@(posedge clk) disable iff (rst)
    (!dsg_inh_n && !test_hold) |=> !dsg_en);
  a_r11_chg_inhibit: assert property (@(posedge clk) disable iff (rst)
    (!chg_inh_n && !uv_sleep && !test_hold) |=> !chg_en);
  a_r12_hold_on: assert property (@(posedge clk) disable iff (rst)
    test_hold |=> (chg_en && dsg_en && uv_fault_n && !sleep));
  a_r6_sleep_blocks: assert property (@(posedge clk) disable iff (rst)
    (sleep) |-> (!dsg_en && !uv_fault_n));
endmodule

// File: tb/sim_pack_guard_ctrl.sv
module sim_pack_guard_ctrl;
  localparam int TDIV = 4;
  localparam int OCT  = 30;
  localparam int SCT  = 3;
  localparam int SLT  = 50;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample_vld = 1'b0;
  logic [2:0] cell_over = '0;
  logic [2:0] cell_under = '0;
  logic       ov_two_sel = 1'b0;
  logic       oc_hit = 1'b0;
  logic       sc_hit = 1'b0;
  logic       charger_det = 1'b0;
  logic       load_gone = 1'b0;
  logic       chg_inh_n = 1'b1;
  logic       dsg_inh_n = 1'b1;
  logic       test_hold = 1'b0;
  logic       chg_en, dsg_en, uv_fault_n, sleep;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pack_guard_ctrl #(
    .N_CELLS(3), .TICK_DIV(TDIV), .OC_TICKS(OCT),
    .SC_TICKS(SCT), .SLEEP_TICKS(SLT)
  ) u0 (
    .clk(clk), .rst(rst), .sample_vld(sample_vld), .cell_over(cell_over),
    .cell_under(cell_under), .ov_two_sel(ov_two_sel), .oc_hit(oc_hit),
    .sc_hit(sc_hit), .charger_det(charger_det), .load_gone(load_gone),
    .chg_inh_n(chg_inh_n), .dsg_inh_n(dsg_inh_n), .test_hold(test_hold),
    .chg_en(chg_en), .dsg_en(dsg_en), .uv_fault_n(uv_fault_n), .sleep(sleep)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic window(input logic [2:0] ov, input logic [2:0] uv);
    @(negedge clk);
    sample_vld = 1'b1; cell_over = ov; cell_under = uv;
    @(negedge clk);
    sample_vld = 1'b0; cell_over = '0; cell_under = '0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    waitn(3);
    rst = 1'b0;
    waitn(1);
    chk("R1 chg_en after reset", chg_en, 1'b1);
    chk("R1 dsg_en after reset", dsg_en, 1'b1);
    chk("R1 uv_fault_n after reset", uv_fault_n, 1'b1);
    chk("R1 sleep after reset", sleep, 1'b0);
  endtask

  task automatic t_ov_single;
    ov_two_sel = 1'b0;
    window(3'b010, 3'b000);
    waitn(1);
    chk("R2 one high window trips", chg_en, 1'b0);
    window(3'b000, 3'b000);
    waitn(1);
    chk("R4 clean window frees charge", chg_en, 1'b1);
  endtask

  task automatic t_ov_double;
    ov_two_sel = 1'b1;
    window(3'b100, 3'b000);
    waitn(1);
    chk("R3 first high window holds", chg_en, 1'b1);
    window(3'b000, 3'b000);
    window(3'b001, 3'b000);
    waitn(1);
    chk("R3 count restarted by clean window", chg_en, 1'b1);
    window(3'b001, 3'b000);
    waitn(1);
    chk("R3 second back-to-back trips", chg_en, 1'b0);
    window(3'b000, 3'b000);
    waitn(1);
    chk("R4 release after two-window trip", chg_en, 1'b1);
    ov_two_sel = 1'b0;
  endtask

  task automatic t_uv_sleep;
    window(3'b000, 3'b001);
    window(3'b000, 3'b000);
    window(3'b000, 3'b100);
    waitn(1);
    chk("R5 single low window no fault", uv_fault_n, 1'b1);
    window(3'b000, 3'b010);
    waitn(1);
    chk("R5 two low windows fault", uv_fault_n, 1'b0);
    charger_det = 1'b1;
    waitn(4);
    charger_det = 1'b0;
    chk("R6 charger ignored in countdown", uv_fault_n, 1'b0);
    waitn(SLT * TDIV + 1 - 5);
    chk("R6 not asleep one edge early", sleep, 1'b0);
    chk("R6 discharge on before sleep", dsg_en, 1'b1);
    waitn(1);
    chk("R6 asleep at end of countdown", sleep, 1'b1);
    chk("R6 discharge off in sleep", dsg_en, 1'b0);
    chg_inh_n = 1'b0;
    waitn(2);
    chk("R11 charge inhibit ignored in sleep", chg_en, 1'b1);
    chg_inh_n = 1'b1;
    waitn(10);
    chk("R7 sleep held without charger", sleep, 1'b1);
    charger_det = 1'b1;
    waitn(1);
    charger_det = 1'b0;
    waitn(1);
    chk("R7 sleep left on charger", sleep, 1'b0);
    chk("R7 fault released on charger", uv_fault_n, 1'b1);
    chk("R7 discharge back on", dsg_en, 1'b1);
  endtask

  task automatic t_oc;
    oc_hit = 1'b1;
    waitn(100);
    oc_hit = 1'b0;
    waitn(1);
    oc_hit = 1'b1;
    waitn(100);
    oc_hit = 1'b0;
    waitn(2);
    chk("R8 broken overcurrent restarts", dsg_en, 1'b1);
    oc_hit = 1'b1;
    waitn(OCT * TDIV + 1);
    chk("R8 not tripped one edge early", dsg_en, 1'b1);
    waitn(1);
    chk("R8 tripped at window", dsg_en, 1'b0);
    oc_hit = 1'b0;
    waitn(3);
    chk("R8 trip stays latched", dsg_en, 1'b0);
    load_gone = 1'b1;
    waitn(1);
    load_gone = 1'b0;
    waitn(1);
    chk("R10 load removal releases", dsg_en, 1'b1);
  endtask

  task automatic t_sc;
    oc_hit = 1'b1; sc_hit = 1'b1;
    waitn(SCT * TDIV + 1);
    chk("R9 short not tripped early", dsg_en, 1'b1);
    waitn(1);
    chk("R9 short tripped at short window", dsg_en, 1'b0);
    oc_hit = 1'b0; sc_hit = 1'b0;
    charger_det = 1'b1;
    waitn(1);
    charger_det = 1'b0;
    waitn(1);
    chk("R10 charger releases", dsg_en, 1'b1);
  endtask

  task automatic t_inhibit;
    dsg_inh_n = 1'b0;
    waitn(1);
    chk("R11 discharge inhibit", dsg_en, 1'b0);
    chk("R11 charge unaffected", chg_en, 1'b1);
    dsg_inh_n = 1'b1;
    chg_inh_n = 1'b0;
    waitn(1);
    chk("R11 charge inhibit", chg_en, 1'b0);
    chk("R11 discharge restored", dsg_en, 1'b1);
    chg_inh_n = 1'b1;
    waitn(1);
    chk("R11 charge restored", chg_en, 1'b1);
  endtask

  task automatic t_test_hold;
    window(3'b001, 3'b000);
    oc_hit = 1'b1; sc_hit = 1'b1;
    waitn(SCT * TDIV + 3);
    oc_hit = 1'b0; sc_hit = 1'b0;
    chk("R12 setup charge tripped", chg_en, 1'b0);
    chk("R12 setup discharge tripped", dsg_en, 1'b0);
    test_hold = 1'b1;
    waitn(1);
    chk("R12 hold charge on", chg_en, 1'b1);
    chk("R12 hold discharge on", dsg_en, 1'b1);
    waitn(2);
    test_hold = 1'b0;
    waitn(3);
    chk("R12 charge cleared after hold", chg_en, 1'b1);
    chk("R12 discharge cleared after hold", dsg_en, 1'b1);
  endtask

  initial begin
    t_reset();
    t_ov_single();
    t_ov_double();
    t_uv_sleep();
    t_oc();
    t_sc();
    t_inhibit();
    t_test_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule